// File: doc/BRIEF.md
# Dual-Channel Serial DAC Command Front End

This block is the digital side of a two-channel digital-to-analog converter. A host sends it 16-bit command words over a three-wire serial link made of a serial clock, a serial data input and an active-low chip select. The block runs on its own system clock. It brings the three serial pins into that clock domain through synchronizers and finds their edges there. Data bits are taken on rising serial-clock edges while chip select is low. When chip select returns high after exactly sixteen such edges, the word is committed.

The top four bits of a word choose an action and the low twelve bits carry a code. Each channel holds a staging register and an output register that drives the converter code. A command can stage a code, move the staged code to the output, or do both at once with a new code. A single command can also move both staged codes together. The shift register's outgoing bit appears on a serial output pin, so several devices can be chained or a word can be read back. The output resolution is set by a parameter to 12, 10 or 8 bits. A narrower part keeps only the upper bits of the data field.

Top module: `dual_dac_ctrl`

## Requirements
- R1: A word is sent most significant bit first. Bits 15..12 form the action field and bits 11..0 form the code field. Bit 11 is the code's most significant bit.
- R2: Data bits are taken only on rising serial-clock edges while chip select is low. While chip select is high, serial-clock activity leaves the shift register unchanged.
- R3: A word takes effect only when chip select rises after exactly 16 rising serial-clock edges. After 15 edges, or after 17 edges, the word is discarded and no register changes.
- R4: Action 0001 loads the channel A staging register and action 0010 loads the channel B staging register. Neither changes any output code.
- R5: Action 1001 copies the channel A staging register to its output register. Action 1010 does the same for channel B.
- R6: Action 0011 writes the new code to both registers of channel A. Action 0100 does the same for channel B.
- R7: Action 1111 copies both staging registers to their output registers in the same cycle.
- R8: Action 0000 and every action not listed above change no register.
- R9: Reset clears every staging and output register to zero.
- R10: The serial output changes only after a falling serial-clock edge. It shows the shift register's most significant bit, so the bit read before each rising edge of a frame is the corresponding bit of the previous 16-bit frame, most significant bit first.
- R11: With resolution RES, each output code is bits 11 down to 12-RES of the code field. The lower bits are ignored. RES must be 8, 10 or 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sck | input | 1 | Serial clock |
| cs_n | input | 1 | Active-low chip select |
| sdi | input | 1 | Serial data input |
| sdo | output | 1 | Serial data output for chaining and readback |
| dac_a | output | RES | Channel A converter code |
| dac_b | output | RES | Channel B converter code |

## Verification
The bench builds two copies that share the same serial pins. One uses RES=12 and the other RES=8, so every frame is checked at full width and at the narrowest width. The 8-bit copy shows that the low four code bits are dropped and that the kept bits line up with bit 11. Codes with only bit 0 or only bit 11 set make the bit order visible at both widths.

// File: rtl/dual_dac_pkg.sv
package dual_dac_pkg;
  localparam int WORD_W = 16;
  localparam int CTRL_W = 4;
  localparam int DATA_W = WORD_W - CTRL_W;
  localparam int NCH    = 2;

  // action field values; per-channel codes are base + channel index
  localparam logic [CTRL_W-1:0] ACT_NOP      = 4'h0;
  localparam logic [CTRL_W-1:0] ACT_STAGE    = 4'h1;
  localparam logic [CTRL_W-1:0] ACT_STAGE_UP = 4'h3;
  localparam logic [CTRL_W-1:0] ACT_COPY     = 4'h9;
  localparam logic [CTRL_W-1:0] ACT_COPY_ALL = 4'hF;

  typedef struct packed {
    logic ld_stage;
    logic ld_out;
    logic cp_out;
  } ch_act_t;
endpackage

// File: rtl/dual_dac_rstsync.sv
module dual_dac_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end

  assign rst_n_sync = rst_q[1];
endmodule

// File: rtl/dual_dac_sync.sv
module dual_dac_sync #(
  parameter int           W       = 3,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] stg_n;
    if (s == 0) begin : g_first
      assign stg_n = d;
    end else begin : g_next
      assign stg_n = stg_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[s] <= RST_VAL;
      else        stg_q[s] <= stg_n;
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/dual_dac_shift.sv
module dual_dac_shift
  import dual_dac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_s,
  input  logic              cs_s,
  input  logic              sdi_s,
  output logic [WORD_W-1:0] word,
  output logic              frame_vld,
  output logic              sck_fall,
  output logic              sdo
);
  localparam int              CNT_W   = $clog2(WORD_W + 2);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(WORD_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);

  logic              sck_d, cs_d;
  logic              sck_rise, cs_rise;
  logic [WORD_W-1:0] sh_q, sh_n;
  logic              sh_en;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic              vld_q, vld_n;
  logic              sdo_q, sdo_n;
  logic              sdo_en;

  // edge detection on synchronized pins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d <= 1'b0;
      cs_d  <= 1'b1;
    end else begin
      sck_d <= sck_s;
      cs_d  <= cs_s;
    end
  end

  assign sck_rise = sck_s & ~sck_d;
  assign sck_fall = ~sck_s & sck_d;
  assign cs_rise  = cs_s & ~cs_d;

  always_comb begin
    sh_en  = sck_rise & ~cs_s;
    sh_n   = {sh_q[WORD_W-2:0], sdi_s};
    if (cs_s)                            cnt_n = '0;
    else if (sh_en && cnt_q != CNT_MAX)  cnt_n = cnt_q + 1'b1;
    else                                 cnt_n = cnt_q;
    vld_n  = cs_rise && (cnt_q == CNT_FULL);
    sdo_en = sck_fall & ~cs_s;
    sdo_n  = sh_q[WORD_W-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
      vld_q <= 1'b0;
      sdo_q <= 1'b0;
    end else begin
      if (sh_en)  sh_q  <= sh_n;
      cnt_q <= cnt_n;
      vld_q <= vld_n;
      if (sdo_en) sdo_q <= sdo_n;
    end
  end

  assign word      = sh_q;
  assign frame_vld = vld_q;
  assign sdo       = sdo_q;
endmodule

// File: rtl/dual_dac_decode.sv
module dual_dac_decode
  import dual_dac_pkg::*;
(
  input  logic                vld,
  input  logic [CTRL_W-1:0]   op,
  output ch_act_t [NCH-1:0]   act
);
  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    localparam logic [CTRL_W-1:0] C_STAGE = CTRL_W'(ACT_STAGE + ch);
    localparam logic [CTRL_W-1:0] C_UP    = CTRL_W'(ACT_STAGE_UP + ch);
    localparam logic [CTRL_W-1:0] C_COPY  = CTRL_W'(ACT_COPY + ch);
    logic ld_stage, ld_out, cp_out;
    assign ld_stage = vld && (op == C_STAGE || op == C_UP);
    assign ld_out   = vld && (op == C_UP);
    assign cp_out   = vld && (op == C_COPY || op == ACT_COPY_ALL);
    assign act[ch]  = {ld_stage, ld_out, cp_out};
  end
endmodule

// File: rtl/dual_dac_chan.sv
module dual_dac_chan
  import dual_dac_pkg::*;
#(
  parameter int RES = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  ch_act_t        act,
  input  logic [RES-1:0] din,
  output logic [RES-1:0] stage_code,
  output logic [RES-1:0] out_code
);
  logic [RES-1:0] stage_q, stage_n;
  logic [RES-1:0] out_q, out_n;
  logic           stage_en, out_en;

  always_comb begin
    stage_en = act.ld_stage;
    stage_n  = din;
    out_en   = act.ld_out | act.cp_out;
    out_n    = act.ld_out ? din : stage_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      out_q   <= '0;
    end else begin
      if (stage_en) stage_q <= stage_n;
      if (out_en)   out_q   <= out_n;
    end
  end

  assign stage_code = stage_q;
  assign out_code   = out_q;
endmodule

// File: rtl/dual_dac_ctrl.sv
module dual_dac_ctrl
  import dual_dac_pkg::*;
#(
  parameter int RES       = 12,
  parameter int SYNC_STGS = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sck,
  input  logic           cs_n,
  input  logic           sdi,
  output logic           sdo,
  output logic [RES-1:0] dac_a,
  output logic [RES-1:0] dac_b
);
  logic              rst_n_i;
  logic [2:0]        pins_s;
  logic              sck_s, cs_s, sdi_s;
  logic [WORD_W-1:0] word;
  logic              frame_vld;
  logic              sck_fall;
  logic [RES-1:0]    code;
  ch_act_t [NCH-1:0] act;
  logic [RES-1:0]    stage_codes [NCH];
  logic [RES-1:0]    out_codes   [NCH];

  dual_dac_rstsync i_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  dual_dac_sync #(.W(3), .STAGES(SYNC_STGS), .RST_VAL(3'b010)) i_sync (
    .clk   (clk),
    .rst_n (rst_n_i),
    .d     ({sck, cs_n, sdi}),
    .q     (pins_s)
  );
  assign {sck_s, cs_s, sdi_s} = pins_s;

  dual_dac_shift i_shift (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .sck_s     (sck_s),
    .cs_s      (cs_s),
    .sdi_s     (sdi_s),
    .word      (word),
    .frame_vld (frame_vld),
    .sck_fall  (sck_fall),
    .sdo       (sdo)
  );

  dual_dac_decode i_dec (
    .vld (frame_vld),
    .op  (word[WORD_W-1 -: CTRL_W]),
    .act (act)
  );

  assign code = word[DATA_W-1 -: RES];

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    dual_dac_chan #(.RES(RES)) i_chan (
      .clk        (clk),
      .rst_n      (rst_n_i),
      .act        (act[ch]),
      .din        (code),
      .stage_code (stage_codes[ch]),
      .out_code   (out_codes[ch])
    );
  end

  assign dac_a = out_codes[0];
  assign dac_b = out_codes[1];
endmodule

// File: rtl/dual_dac_ctrl_chk.sv
module dual_dac_ctrl_chk #(
  parameter int RES = 12
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cs_s,
  input logic           sck_fall,
  input logic           sdo,
  input logic           frame_vld,
  input logic [15:0]    word,
  input logic [RES-1:0] stage_a,
  input logic [RES-1:0] stage_b,
  input logic [RES-1:0] dac_a,
  input logic [RES-1:0] dac_b
);
  initial begin
    a_r11_res_legal: assert (RES == 8 || RES == 10 || RES == 12);
  end

  a_r2_hold_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> $stable(word));

  a_r3_single_commit: assert property (@(posedge clk) disable iff (!rst_n)
    frame_vld |=> !frame_vld);

  a_r4_out_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_vld |=> ($stable(dac_a) && $stable(dac_b)));

  a_r5_copy_a: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_vld && word[15:12] == 4'h9) |=> dac_a == $past(stage_a));

  a_r7_copy_both: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_vld && word[15:12] == 4'hF) |=>
      (dac_a == $past(stage_a) && dac_b == $past(stage_b)));

  a_r10_sdo_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo) |-> $past(sck_fall));
endmodule

bind dual_dac_ctrl dual_dac_ctrl_chk #(.RES(RES)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n_i),
  .cs_s      (cs_s),
  .sck_fall  (sck_fall),
  .sdo       (sdo),
  .frame_vld (frame_vld),
  .word      (word),
  .stage_a   (stage_codes[0]),
  .stage_b   (stage_codes[1]),
  .dac_a     (dac_a),
  .dac_b     (dac_b)
);

// File: tb/test_dual_dac_ctrl.sv
module test_dual_dac_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0;
  logic cs_n = 1'b1;
  logic sdi = 1'b0;
  logic sdo, sdo8;
  logic [11:0] dac_a, dac_b;
  logic [7:0]  dac_a8, dac_b8;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [11:0] m_sa, m_sb, m_da, m_db;
  logic [23:0] q_exp [$];
  string       q_tag [$];
  event        ev_frame;
  logic [15:0] rb;

  always #5 clk = ~clk;

  dual_dac_ctrl #(.RES(12)) i_dual_dac_ctrl (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .sdi(sdi),
    .sdo(sdo), .dac_a(dac_a), .dac_b(dac_b));

  dual_dac_ctrl #(.RES(8)) i_dual_dac_ctrl_r8 (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .sdi(sdi),
    .sdo(sdo8), .dac_a(dac_a8), .dac_b(dac_b8));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // reference model of the command set (R4..R8)
  task automatic model(input logic [15:0] w);
    logic [11:0] d;
    d = w[11:0];
    case (w[15:12])
      4'h1: m_sa = d;
      4'h2: m_sb = d;
      4'h3: begin m_sa = d; m_da = d; end
      4'h4: begin m_sb = d; m_db = d; end
      4'h9: m_da = m_sa;
      4'hA: m_db = m_sb;
      4'hF: begin m_da = m_sa; m_db = m_sb; end
      default: ;
    endcase
  endtask

  // driver: shifts nbits MSB first, records sdo before each rise
  task automatic send(input string tag, input int nbits, input logic [31:0] w);
    cs_n = 1'b0;
    wait_clk(6);
    rb = '0;
    for (int i = nbits - 1; i >= 0; i--) begin
      sdi = w[i];
      wait_clk(6);
      rb = {rb[14:0], sdo};
      sck = 1'b1;
      wait_clk(6);
      sck = 1'b0;
      wait_clk(6);
    end
    cs_n = 1'b1;
    if (nbits == 16) model(w[15:0]);   // R3: only full frames count
    q_exp.push_back({m_da, m_db});
    q_tag.push_back(tag);
    -> ev_frame;
    wait_clk(24);
  endtask

  // monitor: compares outputs of both widths after each frame
  initial begin
    forever begin
      logic [23:0] e;
      string t;
      @(ev_frame);
      wait_clk(14);
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      check({t, " dac_a"}, 32'(dac_a), 32'(e[23:12]));
      check({t, " dac_b"}, 32'(dac_b), 32'(e[11:0]));
      check({t, " R11 dac_a8"}, 32'(dac_a8), 32'(e[23:16]));
      check({t, " R11 dac_b8"}, 32'(dac_b8), 32'(e[11:4]));
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    m_sa = '0; m_sb = '0; m_da = '0; m_db = '0;
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(6);
    // R9: reset state
    check("R9 dac_a", 32'(dac_a), 0);
    check("R9 dac_b", 32'(dac_b), 0);
    check("R9 dac_a8", 32'(dac_a8), 0);
    check("R9 sdo", 32'(sdo), 0);

    send("R4 stage A", 16, 32'h1123);
    send("R5 copy A", 16, 32'h9000);
    send("R4 stage B", 16, 32'h2456);
    send("R5 copy B", 16, 32'hA000);
    send("R6 update A", 16, 32'h3789);
    send("R6 update B", 16, 32'h4ABC);
    send("R4 stage A2", 16, 32'h1111);
    send("R4 stage B2", 16, 32'h2222);
    send("R7 copy both", 16, 32'hF000);
    send("R8 nop", 16, 32'h0FFF);
    send("R8 code5", 16, 32'h5FFF);
    send("R8 code8", 16, 32'h8FFF);
    send("R8 codeE", 16, 32'hEFFF);
    send("R8 copy both after ignored", 16, 32'hF000);
    send("R3 short 15", 15, 32'h00003FFF);
    send("R3 long 17", 17, 32'h0001DDDD);
    send("R1 lsb", 16, 32'h3001);
    send("R1 msb", 16, 32'h3800);
    send("R11 low bits", 16, 32'h4F0F);

    // R10 and R2: readback of previous frame through sdo
    send("R10 first", 16, 32'h0A5C);
    for (int k = 0; k < 5; k++) begin   // R2: sck with cs high
      sdi = 1'b1;
      sck = 1'b1; wait_clk(6);
      sck = 1'b0; wait_clk(6);
    end
    send("R10 second", 16, 32'h0000);
    check("R10 R2 sdo readback", 32'(rb), 32'h0A5C);

    wait_clk(10);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule